// File: doc/BRIEF.md
# Six-Mode Window Shifter

This combinational unit shifts or rotates an N-bit word by an amount from 0 to N-1. It supports logical, arithmetic and rotating shifts in both directions. All six variants share one datapath. A source word of 2N-1 bits is assembled from the operand and a block of N-1 fill bits. A chain of log2(N) stages of 2:1 multiplexers then cuts an N-bit window out of that source word. Each stage is steered by one bit of a window offset.

The variants differ in only two things: what the fill bits contain, and which side of the operand they sit on. For right shifts the fill sits above the operand and the offset is the shift amount itself. For left shifts the fill sits below the operand and the offset is N-1-k. Because N is a power of two, N-1-k is the bitwise inverse of the shift amount, so no subtractor is needed.

The unit is meant to be dropped into an execution datapath. The result follows the inputs with no clock and no state.

Top module: `shift_funnel_unit`

## Requirements
- R1: With `dir_right_i` = 0 (left) and `kind_i` = 2'b00 (logical), `result_o` equals `operand_i` shifted left by `amount_i`, keeping the low N bits and filling vacated low bits with 0.
- R2: With `dir_right_i` = 1 (right) and `kind_i` = 2'b00, `result_o` equals `operand_i` shifted right by `amount_i`, with zeros entering at the top.
- R3: With `dir_right_i` = 1 and `kind_i` = 2'b01 (arithmetic), vacated high bits are filled with copies of `operand_i[N-1]`.
- R4: With `dir_right_i` = 0 and `kind_i` = 2'b01, the result is identical to the left logical shift.
- R5: With `dir_right_i` = 0 and `kind_i` = 2'b10 (rotate), bits leaving at the top re-enter at the bottom: result = (x << k) | (x >> (N-k)).
- R6: With `dir_right_i` = 1 and `kind_i` = 2'b10, bits leaving at the bottom re-enter at the top: result = (x >> k) | (x << (N-k)).
- R7: An `amount_i` of 0 returns `operand_i` unchanged for every direction and kind.
- R8: `kind_i` = 2'b11 is treated exactly as the logical kind in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | DATA_W | Word to be shifted or rotated |
| amount_i | input | $clog2(DATA_W) | Shift distance, 0 to DATA_W-1 |
| dir_right_i | input | 1 | 1 = toward bit 0, 0 = toward the MSB |
| kind_i | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 treated as logical |
| result_o | output | DATA_W | Shifted word |

## Verification
The cases most likely to expose a wrong fill-to-window alignment are the two extreme amounts: k = 0 and k = N-1. At k = 0 a left operation must select the top window of the source word. At k = N-1 almost the whole window comes from fill bits. These cases are hard to reach from random amounts alone, so the stimulus sweeps every amount from 0 to N-1 for every direction and kind code, including the reserved code. Each sweep uses operands chosen to make fill errors visible: all ones, all zeros, a lone MSB, a lone LSB and an alternating pattern. Random operands are added on top of these. Every result is compared with an arithmetic model that uses the language's shift operators rather than a window.

// File: rtl/shift_funnel_pkg.sv
package shift_funnel_pkg;

    typedef enum logic [1:0] {
        KIND_LOGIC  = 2'b00,
        KIND_ARITH  = 2'b01,
        KIND_ROTATE = 2'b10,
        KIND_RSVD   = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic        right;
        shift_kind_e kind;
    } shift_ctrl_t;

    // The reserved code folds onto the logical kind.
    function automatic shift_kind_e fold_kind(input logic [1:0] raw);
        shift_kind_e k;
        k = shift_kind_e'(raw);
        if (k == KIND_RSVD) begin
            k = KIND_LOGIC;
        end
        return k;
    endfunction

    function automatic shift_ctrl_t make_ctrl(input logic right, input logic [1:0] raw);
        shift_ctrl_t c;
        c.right = right;
        c.kind  = fold_kind(raw);
        return c;
    endfunction

endpackage

// File: rtl/shift_source_builder.sv
module shift_source_builder
    import shift_funnel_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int AMT_W = $clog2(DATA_W),
    localparam int FILL_W = DATA_W - 1,
    localparam int SRC_W = DATA_W + FILL_W
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [AMT_W-1:0]  amount,
    input  shift_ctrl_t       ctrl,
    output logic [SRC_W-1:0]  source,
    output logic [AMT_W-1:0]  offset
);

    logic [FILL_W-1:0] fill;

    always_comb begin
        fill = '0;
        case (ctrl.kind)
            KIND_ROTATE: fill = ctrl.right ? operand[FILL_W-1:0] : operand[DATA_W-1:1];
            KIND_ARITH:  fill = ctrl.right ? {FILL_W{operand[DATA_W-1]}} : '0;
            default:     fill = '0;
        endcase
    end

    // Right: fill above operand, offset k. Left: operand above fill, offset N-1-k.
    always_comb begin
        if (ctrl.right) begin
            source = {fill, operand};
            offset = amount;
        end else begin
            source = {operand, fill};
            offset = ~amount;
        end
    end

endmodule

// File: rtl/shift_window_select.sv
module shift_window_select #(
    parameter int DATA_W = 16,
    localparam int AMT_W = $clog2(DATA_W),
    localparam int SRC_W = 2 * DATA_W - 1
) (
    input  logic [SRC_W-1:0]  source,
    input  logic [AMT_W-1:0]  offset,
    output logic [DATA_W-1:0] window
);

    logic [SRC_W-1:0] level [0:AMT_W];

    assign level[0] = source;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign level[s+1] = offset[s] ? (level[s] >> STEP) : level[s];
    end

    assign window = level[AMT_W][DATA_W-1:0];

endmodule

// File: rtl/shift_funnel_unit.sv
module shift_funnel_unit
    import shift_funnel_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int AMT_W = $clog2(DATA_W),
    localparam int SRC_W = 2 * DATA_W - 1
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic [AMT_W-1:0]  amount_i,
    input  logic              dir_right_i,
    input  logic [1:0]        kind_i,
    output logic [DATA_W-1:0] result_o
);

    shift_ctrl_t      ctrl;
    logic [SRC_W-1:0] source_word;
    logic [AMT_W-1:0] win_offset;

    assign ctrl = make_ctrl(dir_right_i, kind_i);

    shift_source_builder #(.DATA_W(DATA_W)) u_build (
        .operand (operand_i),
        .amount  (amount_i),
        .ctrl    (ctrl),
        .source  (source_word),
        .offset  (win_offset)
    );

    shift_window_select #(.DATA_W(DATA_W)) u_window (
        .source (source_word),
        .offset (win_offset),
        .window (result_o)
    );

    always_comb begin
        if (amount_i == '0) begin
            p_zero_amount_r7: assert (result_o == operand_i);
        end
        if (ctrl.kind == KIND_ROTATE) begin
            // covers R5 and R6
            p_rotate_keeps_ones_r5: assert ($countones(result_o) == $countones(operand_i));
        end
        if (dir_right_i && ctrl.kind == KIND_LOGIC && amount_i != '0) begin
            p_lsr_top_zero_r2: assert (result_o[DATA_W-1] == 1'b0);
        end
        if (dir_right_i && ctrl.kind == KIND_ARITH) begin
            p_asr_keeps_sign_r3: assert (result_o[DATA_W-1] == operand_i[DATA_W-1]);
        end
        if (!dir_right_i && ctrl.kind != KIND_ROTATE && amount_i != '0) begin
            // covers R1 and R4
            p_left_low_zero_r1: assert (result_o[0] == 1'b0);
        end
    end

endmodule

// File: tb/shift_funnel_unit_test.sv
module shift_funnel_unit_test;

    localparam int N = 16;
    localparam int AW = $clog2(N);

    typedef struct {
        logic [N-1:0] exp;
        string        tag;
        logic [N-1:0] op;
        int           k;
        logic         right;
        logic [1:0]   kind;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  operand = '0;
    logic [AW-1:0] amount = '0;
    logic          dir_right = 1'b0;
    logic [1:0]    kind = 2'b00;
    logic [N-1:0]  result;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    item_t sb_q[$];

    always #5 clk = ~clk;

    shift_funnel_unit #(.DATA_W(N)) uut (
        .operand_i   (operand),
        .amount_i    (amount),
        .dir_right_i (dir_right),
        .kind_i      (kind),
        .result_o    (result)
    );

    function automatic logic [N-1:0] model(logic [N-1:0] x, int k, logic right, logic [1:0] kd);
        logic [N-1:0]        r;
        logic signed [N-1:0] sx;
        sx = x;
        case (kd)
            2'b10: r = right ? ((x >> k) | (x << (N - k))) : ((x << k) | (x >> (N - k)));
            2'b01: r = right ? N'(sx >>> k) : (x << k);
            default: r = right ? (x >> k) : (x << k);
        endcase
        return r;
    endfunction

    function automatic string req_of(int k, logic right, logic [1:0] kd);
        if (k == 0) return "R7";
        if (kd == 2'b11) return "R8";
        case (kd)
            2'b01: return right ? "R3" : "R4";
            2'b10: return right ? "R6" : "R5";
            default: return right ? "R2" : "R1";
        endcase
    endfunction

    task automatic send(logic [N-1:0] x, int k, logic right, logic [1:0] kd);
        item_t it;
        @(posedge clk);
        #1;
        operand   = x;
        amount    = AW'(k);
        dir_right = right;
        kind      = kd;
        it.exp    = model(x, k, right, kd);
        it.tag    = req_of(k, right, kd);
        it.op     = x;
        it.k      = k;
        it.right  = right;
        it.kind   = kd;
        sb_q.push_back(it);
    endtask

    // monitor: compares half a cycle after each drive
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (result !== it.exp) begin
                errors++;
                $display("FAIL %s op=%h k=%0d right=%0b kind=%0d actual=%h expected=%h",
                         it.tag, it.op, it.k, it.right, it.kind, result, it.exp);
            end
        end
    end

    initial begin
        logic [N-1:0] pats [5];
        pats[0] = '1;
        pats[1] = '0;
        pats[2] = {1'b1, {(N-1){1'b0}}};
        pats[3] = N'(1);
        pats[4] = {(N/2){2'b10}};
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // reset-time vector: zero amount returns operand (R7)
        send(N'(16'hB5C3), 0, 1'b0, 2'b00);
        // low nibble 1011 by one, each kind and direction (R1..R6)
        for (int d = 0; d < 2; d++) begin
            for (int kd = 0; kd < 4; kd++) begin
                send(N'(4'b1011), 1, d[0], kd[1:0]);
                send({4'b1011, {(N-4){1'b0}}}, 1, d[0], kd[1:0]);
            end
        end
        // full sweep of amounts including 0 and N-1 (R1..R8)
        for (int d = 0; d < 2; d++) begin
            for (int kd = 0; kd < 4; kd++) begin
                for (int k = 0; k < N; k++) begin
                    for (int p = 0; p < 5; p++) begin
                        send(pats[p], k, d[0], kd[1:0]);
                    end
                    for (int r = 0; r < 6; r++) begin
                        send(N'($urandom), k, d[0], kd[1:0]);
                    end
                end
            end
        end
        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule